// File: doc/BRIEF.md
# DTMF Tone Synthesizer with Burst Timer

This block turns a 4-bit digit code into a stream of digital samples that carry one of the sixteen dual-tone keypad signals. Two segment oscillators run side by side, one for the low-frequency row tone and one for the high-frequency column tone. Each oscillator divides its period into 32 equal phase segments. The length of one segment, counted in clock cycles, is picked from the digit code, so the tone frequency is set by the segment length rather than by an accumulated phase increment. Each phase addresses a computed sine table. The column table is about 2 dB louder than the row table. The two table words are summed into one output word that is one bit wider than a table entry.

Either group can be sent on its own for test or acknowledgement tones. With the burst timer enabled, loading a code plays the tone for a fixed interval and then stays silent for an equal interval. At the end of the silence a one-cycle ready pulse tells the host that the next digit may be loaded. Call-progress mode doubles both intervals. The timer default is 182,557 cycles, which is 51 ms at a 3.579545 MHz clock. A host can drive the block straight from its control bits. An external converter and filter turn `sample_o` into an analog signal.

Top module: `dtmf_synth`

## Requirements
- R1: The code selects the row/column pair on the keypad grid with rows 697, 770, 852, 941 Hz and columns 1209, 1336, 1477, 1633 Hz. Codes 1 to 9 (0001 to 1001) give digits 1 to 9, in rows of three from the 697 Hz row and columns 1209 to 1477 Hz. 1010 gives 0 (941/1336), 1011 gives * (941/1209), 1100 gives # (941/1477), 1101 to 1111 give A, B and C (697, 770 and 852 Hz with 1633 Hz), and 0000 gives D (941/1633).
- R2: Each tone period has 32 phase segments. A segment lasts 160, 146, 132 or 118 clock cycles for the four rows (lowest frequency first) and 92, 84, 76 or 68 cycles for the four columns. The phase then steps by one and wraps from 31 to 0.
- R3: A table entry equals 2^(TW-1) plus A·sin(2πp/32), truncated toward mid-scale, for phase p. A is A_LO for the row and A_LO·1.26 for the column. `sample_o` is the sum of the two entries, TW+1 bits wide, and follows the phases with one register of latency.
- R4: With `single_i` high only one group sounds. `col_sel_i` high keeps the column and low keeps the row, and the silent group adds 2^(TW-1).
- R5: While the tone is gated off, `sample_o` is 2^TW (mid-scale) and both phases are held at zero. When the tone is gated on again it restarts from phase 0.
- R6: A high `load_i` latches `code_i` and restarts both oscillators at phase 0 and segment count 0.
- R7: With `burst_n_i` low, a load starts a burst that is gated by `tone_en_i` and lasts BURST_CYC cycles. An equal silent pause follows. `ready_o` pulses for exactly one cycle, 2·BURST_CYC cycles after the load edge.
- R8: If `cp_mode_i` is high at the load, the burst and the pause last 2·BURST_CYC cycles each.
- R9: With `burst_n_i` high, `tone_en_i` alone gates the tone, any running burst is abandoned, and `ready_o` stays low.
- R10: A load during a burst or a pause restarts the sequence from the start of a burst with the new code.
- R11: After synchronous reset, `sample_o` is 2^TW and `ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock, nominally 3.579545 MHz |
| rst | input | 1 | Synchronous active-high reset |
| load_i | input | 1 | Strobe that latches the code and, in burst mode, starts a burst |
| code_i | input | 4 | Digit code |
| tone_en_i | input | 1 | Tone output enable |
| burst_n_i | input | 1 | Burst timer enable, active low |
| cp_mode_i | input | 1 | Call-progress mode: doubles the burst and pause lengths, sampled at load |
| single_i | input | 1 | Single-group output |
| col_sel_i | input | 1 | In single-group output, 1 = column, 0 = row |
| sample_o | output | TW+1 | Summed tone sample, unsigned, mid-scale 2^TW |
| ready_o | output | 1 | One-cycle pulse at the end of a burst pause |

## Verification
The checker takes the phase registers to move only by single steps or by a return to zero. It takes `ready_o` to be possible only after a cycle with the burst timer enabled, and the output to be mid-scale one cycle after the tone is gated off. These properties presume a load is one cycle wide and BURST_CYC is at least 2, so that two ready pulses can never be adjacent. The stimulus keeps every load to a single cycle and shortens BURST_CYC to a few hundred cycles so that full burst/pause sequences fit in the run. Mode inputs change only away from the clock edge.

// File: rtl/dtmf_pkg.sv
package dtmf_pkg;

    localparam int PH_W   = 5;
    localparam int SEG_N  = 32;
    localparam int Q_ONE  = 32768;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_TONE = 2'd1,
        SQ_GAP  = 2'd2
    } seq_t;

    typedef struct packed {
        logic [1:0] row;
        logic [1:0] col;
    } pair_t;

    // keypad position for a digit code
    function automatic pair_t digit_pair(input logic [3:0] c);
        pair_t p;
        case (c)
            4'd1:  p = '{row: 2'd0, col: 2'd0};
            4'd2:  p = '{row: 2'd0, col: 2'd1};
            4'd3:  p = '{row: 2'd0, col: 2'd2};
            4'd4:  p = '{row: 2'd1, col: 2'd0};
            4'd5:  p = '{row: 2'd1, col: 2'd1};
            4'd6:  p = '{row: 2'd1, col: 2'd2};
            4'd7:  p = '{row: 2'd2, col: 2'd0};
            4'd8:  p = '{row: 2'd2, col: 2'd1};
            4'd9:  p = '{row: 2'd2, col: 2'd2};
            4'd10: p = '{row: 2'd3, col: 2'd1};
            4'd11: p = '{row: 2'd3, col: 2'd0};
            4'd12: p = '{row: 2'd3, col: 2'd2};
            4'd13: p = '{row: 2'd0, col: 2'd3};
            4'd14: p = '{row: 2'd1, col: 2'd3};
            4'd15: p = '{row: 2'd2, col: 2'd3};
            default: p = '{row: 2'd3, col: 2'd3};
        endcase
        return p;
    endfunction

    // clock cycles per phase segment; is_col selects the high group
    function automatic int unsigned seg_len(input logic is_col, input logic [1:0] idx);
        int unsigned n;
        if (!is_col) begin
            case (idx)
                2'd0: n = 160;
                2'd1: n = 146;
                2'd2: n = 132;
                default: n = 118;
            endcase
        end else begin
            case (idx)
                2'd0: n = 92;
                2'd1: n = 84;
                2'd2: n = 76;
                default: n = 68;
            endcase
        end
        return n;
    endfunction

    // sin(k*pi/16) in Q15 for k = 0..8
    function automatic int quarter_q15(input int k);
        int v;
        case (k)
            0: v = 0;
            1: v = 6393;
            2: v = 12540;
            3: v = 18205;
            4: v = 23170;
            5: v = 27246;
            6: v = 30274;
            7: v = 32138;
            default: v = 32768;
        endcase
        return v;
    endfunction

    // signed offset from mid-scale for phase p, truncated toward zero
    function automatic int sine_off(input logic [PH_W-1:0] p, input int amp);
        int pi_;
        int k;
        int mag;
        pi_ = int'(p);
        if (pi_ < 8)        k = pi_;
        else if (pi_ < 16)  k = 16 - pi_;
        else if (pi_ < 24)  k = pi_ - 16;
        else                k = 32 - pi_;
        mag = (amp * quarter_q15(k)) / Q_ONE;
        return (pi_ < 16) ? mag : -mag;
    endfunction

endpackage

// File: rtl/dtmf_seg_osc.sv
module dtmf_seg_osc
    import dtmf_pkg::*;
#(
    parameter int IS_COL = 0,
    parameter int DIV_W  = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            restart,
    input  logic            run,
    input  logic [1:0]      idx,
    output logic [PH_W-1:0] phase
);

    logic [DIV_W-1:0] div_q;
    logic [DIV_W-1:0] last_cnt;

    assign last_cnt = DIV_W'(seg_len(IS_COL != 0, idx) - 1);

    always_ff @(posedge clk) begin
        if (rst || restart || !run) begin
            div_q <= '0;
            phase <= '0;
        end else if (div_q == last_cnt) begin
            div_q <= '0;
            phase <= phase + 1'b1;
        end else begin
            div_q <= div_q + 1'b1;
        end
    end

endmodule

// File: rtl/dtmf_burst_seq.sv
module dtmf_burst_seq
    import dtmf_pkg::*;
#(
    parameter int BURST_CYC = 182557
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic burst_n,
    input  logic cp_mode,
    output seq_t state,
    output logic ready
);

    localparam int CNT_W = $clog2(2 * BURST_CYC + 1);
    localparam logic [CNT_W-1:0] LAST_STD = CNT_W'(BURST_CYC - 1);
    localparam logic [CNT_W-1:0] LAST_CP  = CNT_W'(2 * BURST_CYC - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SQ_IDLE;
            cnt_q  <= '0;
            last_q <= LAST_STD;
            ready  <= 1'b0;
        end else begin
            ready <= 1'b0;
            if (burst_n) begin
                state <= SQ_IDLE;
                cnt_q <= '0;
            end else if (load) begin
                state  <= SQ_TONE;
                cnt_q  <= '0;
                last_q <= cp_mode ? LAST_CP : LAST_STD;
            end else begin
                case (state)
                    SQ_TONE: begin
                        if (cnt_q == last_q) begin
                            state <= SQ_GAP;
                            cnt_q <= '0;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    SQ_GAP: begin
                        if (cnt_q == last_q) begin
                            state <= SQ_IDLE;
                            cnt_q <= '0;
                            ready <= 1'b1;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                    default: begin
                        state <= SQ_IDLE;
                        cnt_q <= '0;
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/dtmf_mixer.sv
module dtmf_mixer
    import dtmf_pkg::*;
#(
    parameter int TW   = 8,
    parameter int A_LO = 100,
    parameter int A_HI = 126
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            gate,
    input  logic            single,
    input  logic            col_sel,
    input  logic [PH_W-1:0] ph_row,
    input  logic [PH_W-1:0] ph_col,
    output logic [TW:0]     sample
);

    localparam int          MID_T = 2 ** (TW - 1);
    localparam logic [TW-1:0] MID_E = TW'(MID_T);
    localparam logic [TW:0]   MID_S = (TW + 1)'(2 * MID_T);

    logic [PH_W-1:0] ph_arr [2];
    logic [TW-1:0]   ent    [2];
    logic [TW-1:0]   lo_use;
    logic [TW-1:0]   hi_use;
    logic [TW:0]     sum;

    assign ph_arr[0] = ph_row;
    assign ph_arr[1] = ph_col;

    for (genvar g = 0; g < 2; g++) begin : g_tab
        localparam int AMP = (g == 0) ? A_LO : A_HI;
        assign ent[g] = TW'(MID_T + sine_off(ph_arr[g], AMP));
    end

    always_comb begin
        lo_use = (single && col_sel)  ? MID_E : ent[0];
        hi_use = (single && !col_sel) ? MID_E : ent[1];
        sum    = {1'b0, lo_use} + {1'b0, hi_use};
    end

    always_ff @(posedge clk) begin
        if (rst)       sample <= MID_S;
        else if (gate) sample <= sum;
        else           sample <= MID_S;
    end

endmodule

// File: rtl/dtmf_synth.sv
module dtmf_synth
    import dtmf_pkg::*;
#(
    parameter int TW        = 8,
    parameter int A_LO      = 100,
    parameter int BURST_CYC = 182557
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        load_i,
    input  logic [3:0]  code_i,
    input  logic        tone_en_i,
    input  logic        burst_n_i,
    input  logic        cp_mode_i,
    input  logic        single_i,
    input  logic        col_sel_i,
    output logic [TW:0] sample_o,
    output logic        ready_o
);

    localparam int A_HI  = (A_LO * 126) / 100;
    localparam int DIV_W = $clog2(161);

    logic [3:0]      code_q;
    pair_t           pair;
    seq_t            seq_state;
    logic            gate;
    logic [1:0]      grp_idx [2];
    logic [PH_W-1:0] phase_q [2];

    always_ff @(posedge clk) begin
        if (rst)         code_q <= '0;
        else if (load_i) code_q <= code_i;
    end

    assign pair       = digit_pair(code_q);
    assign grp_idx[0] = pair.row;
    assign grp_idx[1] = pair.col;
    assign gate       = tone_en_i && (burst_n_i || (seq_state == SQ_TONE));

    for (genvar g = 0; g < 2; g++) begin : g_osc
        dtmf_seg_osc #(
            .IS_COL (g),
            .DIV_W  (DIV_W)
        ) osc_i (
            .clk     (clk),
            .rst     (rst),
            .restart (load_i),
            .run     (gate),
            .idx     (grp_idx[g]),
            .phase   (phase_q[g])
        );
    end

    dtmf_burst_seq #(
        .BURST_CYC (BURST_CYC)
    ) seq_i (
        .clk     (clk),
        .rst     (rst),
        .load    (load_i),
        .burst_n (burst_n_i),
        .cp_mode (cp_mode_i),
        .state   (seq_state),
        .ready   (ready_o)
    );

    dtmf_mixer #(
        .TW   (TW),
        .A_LO (A_LO),
        .A_HI (A_HI)
    ) mix_i (
        .clk     (clk),
        .rst     (rst),
        .gate    (gate),
        .single  (single_i),
        .col_sel (col_sel_i),
        .ph_row  (phase_q[0]),
        .ph_col  (phase_q[1]),
        .sample  (sample_o)
    );

endmodule

// File: rtl/dtmf_synth_chk.sv
module dtmf_synth_chk #(
    parameter int TW   = 8,
    parameter int A_LO = 100,
    parameter int A_HI = 126
) (
    input logic        clk,
    input logic        rst,
    input logic        load_i,
    input logic        tone_en_i,
    input logic        burst_n_i,
    input logic        ready_o,
    input logic [TW:0] sample_o,
    input logic [4:0]  ph_row,
    input logic [4:0]  ph_col
);

    localparam int MID_S = 2 ** TW;

    // R5: gated-off tone gives mid-scale next cycle
    a_r5_off_midscale: assert property (@(posedge clk) disable iff (rst)
        !tone_en_i |=> (int'(sample_o) == MID_S));

    // R6: load restarts both phases
    a_r6_load_restart: assert property (@(posedge clk) disable iff (rst)
        load_i |=> (ph_row == 5'd0 && ph_col == 5'd0));

    // R2: phases only step by one or return to zero
    a_r2_row_step: assert property (@(posedge clk) disable iff (rst)
        (ph_row != $past(ph_row)) |-> (ph_row == $past(ph_row) + 5'd1 || ph_row == 5'd0));

    a_r2_col_step: assert property (@(posedge clk) disable iff (rst)
        (ph_col != $past(ph_col)) |-> (ph_col == $past(ph_col) + 5'd1 || ph_col == 5'd0));

    // R7: ready is a single-cycle pulse
    a_r7_ready_pulse: assert property (@(posedge clk) disable iff (rst)
        ready_o |=> !ready_o);

    // R9: no ready while the burst timer is disabled
    a_r9_no_ready: assert property (@(posedge clk) disable iff (rst)
        burst_n_i |=> !ready_o);

    // R3: sum stays inside the two amplitudes around mid-scale
    a_r3_range: assert property (@(posedge clk) disable iff (rst)
        (int'(sample_o) >= MID_S - A_LO - A_HI) && (int'(sample_o) <= MID_S + A_LO + A_HI));

endmodule

bind dtmf_synth dtmf_synth_chk #(
    .TW   (TW),
    .A_LO (A_LO),
    .A_HI (A_HI)
) chk_i (
    .clk       (clk),
    .rst       (rst),
    .load_i    (load_i),
    .tone_en_i (tone_en_i),
    .burst_n_i (burst_n_i),
    .ready_o   (ready_o),
    .sample_o  (sample_o),
    .ph_row    (phase_q[0]),
    .ph_col    (phase_q[1])
);

// File: tb/dtmf_synth_tb_top.sv
module dtmf_synth_tb_top;

    localparam int  CLK_PER = 10;
    localparam int  TW      = 8;
    localparam int  A_LO    = 100;
    localparam int  BCYC    = 300;
    localparam real PI      = 3.14159265358979;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        load = 1'b0;
    logic [3:0]  code = 4'd0;
    logic        ten = 1'b0;
    logic        bn = 1'b1;
    logic        cp = 1'b0;
    logic        single = 1'b0;
    logic        colsel = 1'b0;
    logic [TW:0] sample;
    logic        ready;

    int    n_chk = 0;
    int    n_bad = 0;
    string cur_req = "R11";
    int    ready_seen = 0;

    always #(CLK_PER / 2) clk = ~clk;

    dtmf_synth #(.TW(TW), .A_LO(A_LO), .BURST_CYC(BCYC)) dut_i (
        .clk(clk), .rst(rst), .load_i(load), .code_i(code),
        .tone_en_i(ten), .burst_n_i(bn), .cp_mode_i(cp),
        .single_i(single), .col_sel_i(colsel),
        .sample_o(sample), .ready_o(ready)
    );

    // ---------------- reference model ----------------
    real row_hz [4] = '{699.1, 766.2, 847.4, 948.0};
    real col_hz [4] = '{1215.9, 1331.7, 1471.9, 1645.0};
    string keypad = "123A456B789C*0#D";

    function automatic int seg_of(int is_col, int idx);
        real f;
        f = is_col ? col_hz[idx] : row_hz[idx];
        return $rtoi(3579545.0 / (32.0 * f) + 0.5);
    endfunction

    function automatic byte key_of(int c);
        if (c >= 1 && c <= 9) return byte'(8'd48 + c[7:0]);
        case (c)
            10: return "0";
            11: return "*";
            12: return "#";
            13: return "A";
            14: return "B";
            15: return "C";
            default: return "D";
        endcase
    endfunction

    function automatic int pos_of(int c);
        for (int i = 0; i < 16; i++)
            if (keypad[i] == key_of(c)) return i;
        return 0;
    endfunction

    function automatic real tone(int p, real amp);
        return real'(2 ** (TW - 1)) + amp * $sin(2.0 * PI * real'(p) / 32.0);
    endfunction

    int  m_div [2];
    int  m_ph  [2];
    int  m_code;
    int  m_st;      // 0 idle, 1 burst, 2 pause
    int  m_cnt;
    int  m_len;
    real m_samp;
    bit  m_ready;
    real a_hi;

    initial a_hi = real'(A_LO) * (10.0 ** (2.0 / 20.0));

    always @(posedge clk) begin
        bit  gate;
        int  rr, cc;
        real lo, hi;
        if (rst) begin
            m_div = '{0, 0}; m_ph = '{0, 0};
            m_code = 0; m_st = 0; m_cnt = 0; m_len = BCYC;
            m_samp = real'(2 ** TW); m_ready = 0;
        end else begin
            gate = ten && (bn || m_st == 1);
            lo = single && colsel  ? real'(2 ** (TW - 1)) : tone(m_ph[0], real'(A_LO));
            hi = single && !colsel ? real'(2 ** (TW - 1)) : tone(m_ph[1], a_hi);
            m_samp = gate ? lo + hi : real'(2 ** TW);
            rr = pos_of(m_code) / 4;
            cc = pos_of(m_code) % 4;
            // oscillators
            if (load) begin
                m_code = int'(code); m_div = '{0, 0}; m_ph = '{0, 0};
            end else if (gate) begin
                for (int g = 0; g < 2; g++) begin
                    if (m_div[g] == seg_of(g, g == 0 ? rr : cc) - 1) begin
                        m_div[g] = 0; m_ph[g] = (m_ph[g] + 1) % 32;
                    end else m_div[g] = m_div[g] + 1;
                end
            end else begin
                m_div = '{0, 0}; m_ph = '{0, 0};
            end
            // sequencer
            m_ready = 0;
            if (bn) begin
                m_st = 0; m_cnt = 0;
            end else if (load) begin
                m_st = 1; m_cnt = 0; m_len = cp ? 2 * BCYC : BCYC;
            end else if (m_st != 0) begin
                if (m_cnt == m_len - 1) begin
                    m_cnt = 0;
                    if (m_st == 1) m_st = 2;
                    else begin m_st = 0; m_ready = 1; end
                end else m_cnt = m_cnt + 1;
            end
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        real d;
        d = real'(sample) - m_samp;
        if (d < 0.0) d = -d;
        n_chk++;
        if (d > 2.5) begin
            n_bad++;
            $display("FAIL %s sample: actual %0d expected %0.2f at %0t", cur_req, sample, m_samp, $time);
        end
        n_chk++;
        if (ready !== m_ready) begin
            n_bad++;
            $display("FAIL %s ready: actual %0b expected %0b at %0t", cur_req, ready, m_ready, $time);
        end
        if (ready) ready_seen++;
    end

    task automatic cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_load(int c);
        load = 1'b1; code = 4'(c);
        cyc(1);
        load = 1'b0;
    endtask

    task automatic check_eq(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        #(CLK_PER * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst = 1'b0;
        @(negedge clk);
        check_eq("R11 reset sample", int'(sample), 2 ** TW);
        check_eq("R11 reset ready", int'(ready), 0);
        cyc(1);

        // R1: every code in continuous mode
        cur_req = "R1"; bn = 1'b1; ten = 1'b1;
        for (int c = 0; c < 16; c++) begin
            do_load(c);
            cyc(1500);
        end

        // R2 / R3: full periods of slowest row and fastest column
        cur_req = "R2"; do_load(13); cyc(5200);
        cur_req = "R3"; do_load(12); cyc(4000);

        // R4: single group output
        cur_req = "R4"; single = 1'b1; colsel = 1'b0; do_load(5); cyc(2600);
        colsel = 1'b1; cyc(1500);
        single = 1'b0;

        // R5: gate off then on
        cur_req = "R5"; ten = 1'b0; cyc(60);
        @(negedge clk); check_eq("R5 idle midscale", int'(sample), 2 ** TW);
        cyc(1); ten = 1'b1; cyc(700);

        // R6: reload mid-tone
        cur_req = "R6"; cyc(333); do_load(9); cyc(600);

        // R7: burst in DTMF mode
        cur_req = "R7"; bn = 1'b0; cp = 1'b0; ready_seen = 0;
        do_load(7); cyc(2 * BCYC + 50);
        check_eq("R7 one ready pulse", ready_seen, 1);

        // R8: call-progress doubling
        cur_req = "R8"; cp = 1'b1; ready_seen = 0;
        do_load(3); cyc(2 * BCYC + 50);
        check_eq("R8 no ready at single length", ready_seen, 0);
        cyc(2 * BCYC);
        check_eq("R8 ready at doubled length", ready_seen, 1);
        cp = 1'b0;

        // R10: reload during burst and during pause
        cur_req = "R10"; ready_seen = 0;
        do_load(1); cyc(BCYC / 2); do_load(15); cyc(BCYC + 20);
        do_load(4); cyc(2 * BCYC + 50);
        check_eq("R10 single ready after restarts", ready_seen, 1);

        // R9: leave burst mode mid-burst
        cur_req = "R9"; ready_seen = 0;
        do_load(8); cyc(100); bn = 1'b1; cyc(2 * BCYC + 100);
        check_eq("R9 no ready after abort", ready_seen, 0);
        ten = 1'b0; cyc(20);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule